// File: doc/BRIEF.md
# Descriptor Ring Pointer Engine

This block keeps track of where a receive ring and a transmit ring of 8-byte descriptors live in host memory. It also drives the single bus-master port that fetches descriptors and writes them back. Both rings share one 1 KB-aligned region. The upper address byte comes from a page register and address bits 23..10 come from a base register. Receive descriptors occupy the lower 512 bytes of the region and transmit descriptors the upper 512 bytes. Each ring runs its own four-state machine: idle, fetching, holding an active descriptor, and closing it.

Software programs the base, size and page registers through a small write port. Writing to the prompt slot starts every ring that is currently idle. An idle ring issues a read cycle for the descriptor at its current index, then holds that descriptor until the data path signals that the ring is done with it. It then issues a write-back cycle to the same address and advances its index, wrapping at the configured ring size. The two rings share the bus port under round-robin arbitration, and each bus cycle is a single transfer that stays asserted until it is acknowledged. Clearing the master enable returns both rings to idle and zeroes both indices.

Top module: `ring_ptr_engine`

## Requirements
- R1: After a synchronous reset, `bm_req` is 0, `ptr_rb` reads 0x0000, `ring_active` is 0 and all configuration registers are 0.
- R2: A write with `cfg_sel`=3 (prompt, data ignored) moves each idle ring to fetch. The fetch is a bus read (`bm_write`=0) at the ring's current descriptor address.
- R3: A descriptor address is {page[7:0], base[13:0], ring bit, index[5:0], 3'b000}, where the ring bit is 0 for receive and 1 for transmit, so the transmit ring sits 512 bytes above the receive ring. `cfg_sel`=0 loads base from `cfg_wdata[13:0]` and `cfg_sel`=2 loads page from `cfg_wdata[7:0]`.
- R4: A prompt has no effect on a ring that is fetching, active or closing; no further bus cycle is issued for it.
- R5: After its fetch is acknowledged a ring reports active (`ring_active` bit 0 = receive, bit 1 = transmit) until its `ring_done` bit is seen. It then issues a bus write (`bm_write`=1) to the same descriptor address.
- R6: `cfg_sel`=1 loads the transmit size code from `cfg_wdata[15:12]` and the receive size code from `cfg_wdata[11:8]`. The codes 0000, 0001, 0011, 0111 and 1111 select 4, 8, 16, 32 and 64 entries. When a close is acknowledged the index advances by one, and it wraps to 0 from entry count minus one.
- R7: `ptr_rb` shows the receive index in bits [5:0] and the transmit index in bits [13:8]; all other bits read 0.
- R8: While `master_en` is 0, both rings are held idle with index 0 and no bus cycle is requested. This takes effect on the next clock edge, even in the middle of a transfer.
- R9: When both rings request the idle bus together, the ring that did not win the previous grant is served first; receive wins the first contest after reset.
- R10: Every bus cycle is a single transfer. `bm_req`, `bm_addr` and `bm_write` hold steady until the edge at which `bm_ack` is seen, and `bm_req` drops after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Enables bus mastering; when low, rings are idle and indices are zero |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 base, 1 size, 2 page, 3 prompt |
| cfg_wdata | input | 16 | Write data |
| ring_done | input | 2 | Data path finished with the active descriptor (bit 0 receive, bit 1 transmit) |
| bm_req | output | 1 | Bus-master cycle request |
| bm_write | output | 1 | 1 = descriptor write-back, 0 = descriptor fetch |
| bm_addr | output | 32 | Descriptor byte address |
| bm_ack | input | 1 | Bus cycle completed |
| ptr_rb | output | 16 | Read-back of both ring indices |
| ring_active | output | 2 | Ring holds a fetched descriptor |

## Verification
A prompt written at clock edge n puts the first request on `bm_req` after edge n+1. A ring's active flag, and its index in `ptr_rb`, change at the same edge that samples `bm_ack` for its fetch or close. A `ring_done` sampled at an edge raises the write-back request one edge later. Dropping `master_en` clears everything at the following edge. The bench drives inputs on falling edges and keeps a behavioural model that it steps on each rising edge. On every falling edge it compares the request, address, direction, read-back and active flags against that model, so each result is checked in exactly the cycle it is due. Directed checks then confirm addresses, wrap points and arbitration order from a log of acknowledged cycles.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

    localparam int RING_N  = 2;
    localparam int CODE_W  = 4;
    localparam int IDX_W   = CODE_W + 2;
    localparam int PAGE_W  = 8;
    localparam int BASE_W  = 14;
    localparam int DESC_SH = 3;
    localparam int WDATA_W = 16;
    localparam int OWN_W   = $clog2(RING_N);
    localparam int ADDR_W  = PAGE_W + BASE_W + 1 + IDX_W + DESC_SH;
    localparam int RB_LANE = 8;
    localparam int RB_W    = RB_LANE * RING_N;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_FETCH  = 2'd1,
        RS_ACTIVE = 2'd2,
        RS_CLOSE  = 2'd3
    } ring_st_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_KICK = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] tx_code;
        logic [CODE_W-1:0] rx_code;
    } ring_cfg_t;

    // last legal index for a thermometer size code: entries = (code+1)*4
    function automatic logic [IDX_W-1:0] last_index(input logic [CODE_W-1:0] code);
        return {code, 2'b11};
    endfunction

    function automatic logic [IDX_W-1:0] step_index(input logic [IDX_W-1:0] cur,
                                                    input logic [CODE_W-1:0] code);
        return (cur >= last_index(code)) ? '0 : cur + 1'b1;
    endfunction

    function automatic logic [ADDR_W-1:0] desc_addr(input ring_cfg_t c,
                                                    input logic ring_tx,
                                                    input logic [IDX_W-1:0] idx);
        return {c.page, c.base, ring_tx, idx, {DESC_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/rpe_cfg_regs.sv
module rpe_cfg_regs
    import rpe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [WDATA_W-1:0] cfg_wdata,
    output ring_cfg_t          cfg,
    output logic               kick
);

    wr_sel_e sel;
    assign sel  = wr_sel_e'(cfg_sel);
    assign kick = cfg_we && (sel == SEL_KICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_BASE: cfg.base    <= cfg_wdata[BASE_W-1:0];
                SEL_PAGE: cfg.page    <= cfg_wdata[PAGE_W-1:0];
                SEL_SIZE: begin
                    cfg.tx_code <= cfg_wdata[WDATA_W-1 -: CODE_W];
                    cfg.rx_code <= cfg_wdata[WDATA_W-1-CODE_W -: CODE_W];
                end
                default: ;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

endmodule

// File: rtl/rpe_ring_fsm.sv
module rpe_ring_fsm
    import rpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              kick,
    input  logic              done,
    input  logic              gnt_ack,
    input  logic [CODE_W-1:0] code,
    output logic              req,
    output ring_st_e          st,
    output logic [IDX_W-1:0]  idx
);

    ring_st_e         st_n;
    logic [IDX_W-1:0] idx_n;

    always_comb begin
        st_n  = st;
        idx_n = idx;
        unique case (st)
            RS_IDLE:   if (kick)    st_n = RS_FETCH;
            RS_FETCH:  if (gnt_ack) st_n = RS_ACTIVE;
            RS_ACTIVE: if (done)    st_n = RS_CLOSE;
            RS_CLOSE:  if (gnt_ack) begin
                st_n  = RS_IDLE;
                idx_n = step_index(idx, code);
            end
            default:   st_n = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st  <= RS_IDLE;
            idx <= '0;
        end else begin
            st  <= st_n;
            idx <= idx_n;
        end
    end

    assign req = (st == RS_FETCH) || (st == RS_CLOSE);

    // R4
    busy_ring_ignores_kick_chk: assert property (@(posedge clk) disable iff (rst || !run)
        (st == RS_ACTIVE && kick && !done) |=> (st == RS_ACTIVE));

    // R6
    index_step_chk: assert property (@(posedge clk) disable iff (rst || !run)
        (st == RS_CLOSE && gnt_ack) |=> (idx == '0 || idx == $past(idx) + 1'b1));

    // R8
    disabled_ring_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (idx == '0 && st == RS_IDLE));

endmodule

// File: rtl/rpe_bus_arb.sv
module rpe_bus_arb
    import rpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RING_N-1:0] req,
    input  logic              bm_ack,
    output logic              busy,
    output logic [OWN_W-1:0]  owner,
    output logic [RING_N-1:0] gnt_ack
);

    logic [OWN_W-1:0] pick;

    // owner doubles as the last-served record for round robin
    always_comb begin
        if (&req) pick = ~owner;
        else      pick = req[1] ? OWN_W'(1) : OWN_W'(0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy  <= 1'b0;
            owner <= OWN_W'(1);
        end else if (busy) begin
            if (bm_ack) busy <= 1'b0;
        end else if (|req) begin
            busy  <= 1'b1;
            owner <= pick;
        end
    end

    for (genvar g = 0; g < RING_N; g++) begin : g_ack
        assign gnt_ack[g] = busy && bm_ack && (owner == OWN_W'(g));
    end

    // R9
    rr_alternate_chk: assert property (@(posedge clk) disable iff (rst || !run)
        (!busy && (&req)) |=> (busy && owner != $past(owner)));

    // R10
    single_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst || !run)
        (busy && !bm_ack) |=> (busy && $stable(owner)));

endmodule

// File: rtl/ring_ptr_engine.sv
module ring_ptr_engine
    import rpe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               master_en,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [WDATA_W-1:0] cfg_wdata,
    input  logic [RING_N-1:0]  ring_done,
    output logic               bm_req,
    output logic               bm_write,
    output logic [ADDR_W-1:0]  bm_addr,
    input  logic               bm_ack,
    output logic [RB_W-1:0]    ptr_rb,
    output logic [RING_N-1:0]  ring_active
);

    ring_cfg_t         cfg;
    logic              kick;
    logic [RING_N-1:0] req;
    logic [RING_N-1:0] gnt_ack;
    logic [OWN_W-1:0]  owner;
    ring_st_e          st  [RING_N];
    logic [IDX_W-1:0]  idx [RING_N];

    rpe_cfg_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .kick      (kick)
    );

    for (genvar g = 0; g < RING_N; g++) begin : g_ring
        logic [CODE_W-1:0] code;
        assign code = (g == 0) ? cfg.rx_code : cfg.tx_code;

        rpe_ring_fsm i_fsm (
            .clk     (clk),
            .rst     (rst),
            .run     (master_en),
            .kick    (kick),
            .done    (ring_done[g]),
            .gnt_ack (gnt_ack[g]),
            .code    (code),
            .req     (req[g]),
            .st      (st[g]),
            .idx     (idx[g])
        );

        assign ring_active[g] = (st[g] == RS_ACTIVE);
        assign ptr_rb[g*RB_LANE +: RB_LANE] = {{(RB_LANE-IDX_W){1'b0}}, idx[g]};
    end

    rpe_bus_arb i_arb (
        .clk     (clk),
        .rst     (rst),
        .run     (master_en),
        .req     (req),
        .bm_ack  (bm_ack),
        .busy    (bm_req),
        .owner   (owner),
        .gnt_ack (gnt_ack)
    );

    assign bm_write = (st[owner] == RS_CLOSE);
    assign bm_addr  = desc_addr(cfg, owner[0], idx[owner]);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bm_req && ptr_rb == '0 && ring_active == '0));

    // R10
    bus_cycle_stable_chk: assert property (@(posedge clk) disable iff (rst || !master_en)
        (bm_req && !bm_ack) |=> (bm_req && $stable(bm_addr) && $stable(bm_write)));

    // R10
    bus_cycle_ends_chk: assert property (@(posedge clk) disable iff (rst || !master_en)
        (bm_req && bm_ack) |=> !bm_req);

    // R8
    disabled_no_request_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> !bm_req);

endmodule

// File: tb/test_ring_ptr_engine.sv
`timescale 1ns/1ps
module test_ring_ptr_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [1:0]  ring_done = 2'b00;
    logic        bm_ack = 1'b0;
    logic        bm_req, bm_write;
    logic [31:0] bm_addr;
    logic [15:0] ptr_rb;
    logic [1:0]  ring_active;

    int errors = 0;
    int checks = 0;
    int hold   = 0;
    bit ended  = 0;
    logic [32:0] log_q[$];

    int m_st[2], m_idx[2], m_busy, m_own;
    int m_page, m_base, m_rxc, m_txc;

    always #2.5 clk = ~clk;

    ring_ptr_engine i_ring_ptr_engine (
        .clk(clk), .rst(rst), .master_en(master_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ring_done(ring_done), .bm_req(bm_req), .bm_write(bm_write),
        .bm_addr(bm_addr), .bm_ack(bm_ack), .ptr_rb(ptr_rb),
        .ring_active(ring_active)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        int ga[2];
        int rq[2];
        int lim;
        if (rst) begin
            m_page = 0; m_base = 0; m_rxc = 0; m_txc = 0;
        end
        if (rst || !master_en) begin
            m_st[0] = 0; m_st[1] = 0; m_idx[0] = 0; m_idx[1] = 0;
            m_busy = 0; m_own = 1;
        end else begin
            for (int r = 0; r < 2; r++) begin
                ga[r] = (m_busy != 0 && m_own == r && bm_ack) ? 1 : 0;
                rq[r] = (m_st[r] == 1 || m_st[r] == 3) ? 1 : 0;
            end
            if (m_busy != 0) begin
                if (bm_ack) m_busy = 0;
            end else if (rq[0] != 0 || rq[1] != 0) begin
                if (rq[0] != 0 && rq[1] != 0) m_own = 1 - m_own;
                else m_own = (rq[1] != 0) ? 1 : 0;
                m_busy = 1;
            end
            for (int r = 0; r < 2; r++) begin
                lim = ((r == 1) ? m_txc : m_rxc) * 4 + 3;
                case (m_st[r])
                    0: if (cfg_we && cfg_sel == 2'd3) m_st[r] = 1;
                    1: if (ga[r] != 0) m_st[r] = 2;
                    2: if (ring_done[r]) m_st[r] = 3;
                    default: if (ga[r] != 0) begin
                        m_idx[r] = (m_idx[r] >= lim) ? 0 : m_idx[r] + 1;
                        m_st[r] = 0;
                    end
                endcase
            end
        end
        if (!rst && cfg_we) begin
            case (cfg_sel)
                2'd0: m_base = int'(cfg_wdata) & 16'h3fff;
                2'd1: begin m_rxc = (int'(cfg_wdata) >> 8) & 15; m_txc = (int'(cfg_wdata) >> 12) & 15; end
                2'd2: m_page = int'(cfg_wdata) & 255;
                default: ;
            endcase
        end
    end

    // compare, log acknowledged cycles, respond on the bus
    always @(negedge clk) begin
        logic [31:0] ea;
        if (!rst && !ended) begin
            check(bm_req === (m_busy != 0), "R10 cycle request", 64'(bm_req), 64'(m_busy));
            if (m_busy != 0) begin
                ea = (32'(m_page) << 24) | (32'(m_base) << 10) | (32'(m_own) << 9) | (32'(m_idx[m_own]) << 3);
                check(bm_addr === ea, "R3 cycle address", 64'(bm_addr), 64'(ea));
                check(bm_write === (m_st[m_own] == 3), "R5 cycle direction", 64'(bm_write), 64'(m_st[m_own] == 3));
            end
            check(ptr_rb === 16'((m_idx[1] << 8) | m_idx[0]), "R7 cycle readback", 64'(ptr_rb), 64'((m_idx[1] << 8) | m_idx[0]));
            check(ring_active === {m_st[1] == 2, m_st[0] == 2}, "R4 cycle active", 64'(ring_active), 64'({m_st[1] == 2, m_st[0] == 2}));
        end
        if (bm_req && !bm_ack) begin
            if (hold > 0) hold--;
            else begin
                log_q.push_back({bm_write, bm_addr});
                bm_ack = 1'b1;
            end
        end else begin
            bm_ack = 1'b0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick();
        wr(2'd3, 16'hBEEF);
    endtask

    task automatic finish_pulse(input logic [1:0] m);
        @(negedge clk);
        ring_done = m;
        @(negedge clk);
        ring_done = 2'b00;
    endtask

    task automatic round(input int r);
        kick();
        cyc(8);
        finish_pulse(2'(1 << r));
        cyc(8);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    localparam logic [31:0] RX0 = 32'hA504_8C00;
    localparam logic [31:0] TX0 = 32'hA504_8E00;

    initial begin
        int n;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(bm_req == 1'b0 && ring_active == 2'b00, "R1 reset outputs", {bm_req, ring_active}, 0);
        check(ptr_rb == 16'h0, "R1 reset readback", ptr_rb, 0);

        master_en = 1'b1;
        wr(2'd0, 16'h0123);
        wr(2'd2, 16'h00A5);
        wr(2'd1, 16'h0100);         // rx 8 entries, tx 4 entries
        kick();
        cyc(10);
        check(log_q.size() == 2, "R2 two fetches", log_q.size(), 2);
        // R2 R9: receive served first after reset
        check(log_q[0] == {1'b0, RX0}, "R2 rx fetch", log_q[0], {1'b0, RX0});
        // R3: transmit ring 512 bytes higher
        check(log_q[1] == {1'b0, TX0}, "R3 tx fetch", log_q[1], {1'b0, TX0});
        check(ring_active == 2'b11, "R5 both active", ring_active, 2'b11);

        kick();
        cyc(10);
        check(log_q.size() == 2, "R4 prompt ignored", log_q.size(), 2);
        check(ring_active == 2'b11, "R4 still active", ring_active, 2'b11);

        hold = 3;                   // R10 delayed acknowledge
        finish_pulse(2'b01);
        cyc(10);
        check(log_q[2] == {1'b1, RX0}, "R5 rx close", log_q[2], {1'b1, RX0});
        check(ptr_rb == 16'h0001, "R5 rx index advanced", ptr_rb, 16'h0001);
        check(ring_active == 2'b10, "R5 rx released", ring_active, 2'b10);

        for (int k = 0; k < 6; k++) round(0);
        check(ptr_rb[5:0] == 6'd7, "R6 rx at last entry", ptr_rb[5:0], 7);
        round(0);
        check(ptr_rb[5:0] == 6'd0, "R6 rx wrap at 8", ptr_rb[5:0], 0);

        finish_pulse(2'b10);
        cyc(8);
        round(1);
        round(1);
        check(ptr_rb[13:8] == 6'd3, "R6 tx at last entry", ptr_rb[13:8], 3);
        round(1);
        check(ptr_rb[13:8] == 6'd0, "R6 tx wrap at 4", ptr_rb[13:8], 0);

        for (int k = 0; k < 5; k++) round(0);
        round(1);
        round(1);
        check(ptr_rb == 16'h0205, "R7 readback layout", ptr_rb, 16'h0205);

        kick();
        cyc(8);
        n = log_q.size();
        finish_pulse(2'b11);
        cyc(10);
        check(log_q.size() == n + 2, "R9 two closes", log_q.size(), n + 2);
        check(log_q[n][9] != log_q[n+1][9], "R9 alternating rings", log_q[n+1][9], !log_q[n][9]);

        kick();
        cyc(8);
        hold = 5;
        finish_pulse(2'b01);
        cyc(2);
        @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        check(ptr_rb == 16'h0 && ring_active == 2'b00, "R8 cleared", {ptr_rb, ring_active}, 0);
        check(bm_req == 1'b0, "R8 no request", bm_req, 0);
        hold = 0;
        cyc(3);
        master_en = 1'b1;
        kick();
        cyc(10);
        check(log_q[log_q.size()-2] == {1'b0, RX0}, "R8 restart at index 0", log_q[log_q.size()-2], {1'b0, RX0});

        master_en = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        wr(2'd1, 16'hF000);         // tx 64 entries
        for (int k = 0; k < 63; k++) round(1);
        check(ptr_rb[13:8] == 6'd63, "R6 tx at entry 63", ptr_rb[13:8], 63);
        round(1);
        check(ptr_rb[13:8] == 6'd0, "R6 tx wrap at 64", ptr_rb[13:8], 0);

        cyc(4);
        summary();
    end

endmodule